// File: doc/BRIEF.md
# Low-power wake-pin debouncer

This block qualifies two external wake-up pins against a slow time base. Each pin passes through a two-flop synchroniser and is compared with its own programmed active level. While a pin is enabled and held in its active state, its counter advances once per pulse on the slow tick input. When the count reaches the number of ticks selected by a shared 3-bit period code, the block declares a debounce event for that pin.

An event produces a one-cycle wake-up request. It also sets a sticky per-pin status bit that stays set until the status is read. If the clear option is selected, the event also produces a one-cycle clear strobe for the lower half of a backup register bank. Once a pin has fired, it must return to its inactive level before it can fire again. A pin that leaves its active level before the count is reached starts again from zero.

Top module: `lp_wake_debouncer`

## Requirements
- R1: The 3-bit `period_i` code k (1..7) requires the pin to be seen active on k+1 ticks. Clock cycles without `tick_i` do not advance the count. Code 0 disables both channels.
- R2: A pin whose bit in `pin_en_i` is 0 never produces a wake pulse, a clear strobe or a status bit.
- R3: An event drives `wake_o` high for exactly one clock cycle. That cycle follows the clock edge on which the qualifying tick was sampled. Events on both pins in the same cycle give a single pulse.
- R4: `status_o[i]` belongs to pin i. It goes to 1 one cycle after the wake pulse for that pin. It returns to 0 on the edge where `status_rd_i` is sampled high. If an event and a read coincide, the bit stays 1.
- R5: With `clr_en_i`=1, `bkp_clr_o` pulses for one cycle together with `wake_o`. With `clr_en_i`=0, it stays low.
- R6: If a pin goes inactive before its count is reached, its count restarts from zero.
- R7: After an event, a pin that stays active produces no further event until it has been inactive.
- R8: `pol_i[i]`=1 makes pin i active high. `pol_i[i]`=0 makes it active low.
- R9: Pins pass through two synchronising flops, so ticks on the first two clock edges after a pin change are not counted.
- R10: While `rst_ni` is low, `wake_o`, `bkp_clr_o` and `status_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable marking each slow clock period |
| pin_i | input | 2 | Raw wake-up pins |
| pol_i | input | 2 | Active level per pin (1 = high) |
| pin_en_i | input | 2 | Per-pin debouncer enable |
| period_i | input | 3 | Period code, 0 = off, k = k+1 ticks |
| clr_en_i | input | 1 | Allow events to strobe the backup clear |
| status_rd_i | input | 1 | Status read strobe, clears sticky bits |
| wake_o | output | 1 | One-cycle wake-up request |
| status_o | output | 2 | Sticky per-pin event flags |
| bkp_clr_o | output | 1 | One-cycle clear for the lower backup half |

## Verification
The hardest case to reach is an event whose status set lands on the same edge as a status read. Only then does the set-over-clear priority become visible. The bench steps the tick one cycle at a time up to the final qualifying tick. It then raises the read strobe in the cycle where the wake pulse is visible, so the read is sampled on the same edge that sets the status bit. Counter restart and re-arm use the same tick-by-tick control. The pin toggles after a known number of ticks, with no event allowed in between.

// File: rtl/lpdb_pkg.sv
package lpdb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HELD  = 2'd2
  } ch_state_e;

  // period code k selects k+1 qualifying ticks
  function automatic int unsigned ticks_for_code(input int unsigned code);
    return code + 1;
  endfunction

endpackage

// File: rtl/lpdb_sync.sv
module lpdb_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/lpdb_channel.sv
module lpdb_channel
  import lpdb_pkg::*;
#(
  parameter int unsigned PERIOD_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                active_i,
  input  logic                enable_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                evt_o
);

  localparam int unsigned CNT_W = PERIOD_W + 1;

  ch_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CNT_W-1:0]  need;
  logic              evt_q, evt_d;
  logic              armed;

  assign armed   = enable_i && (period_i != '0);
  assign need    = CNT_W'(ticks_for_code(int'(period_i)));
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    evt_d   = 1'b0;
    if (!armed || !active_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (state_q != ST_HELD && tick_i) begin
      if (cnt_inc >= need) begin
        evt_d   = 1'b1;
        state_d = ST_HELD;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_inc;
        state_d = ST_COUNT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      evt_q   <= evt_d;
    end
  end

  assign evt_o = evt_q;

  assert_evt_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> $past(tick_i));

  assert_no_evt_disarmed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> !evt_q);

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q);

  assert_cnt_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0));

  assert_held_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD && active_i && armed) |=> !evt_q);

endmodule

// File: rtl/lpdb_status.sv
module lpdb_status #(
  parameter int unsigned NUM_PINS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic                rd_i,
  input  logic                clr_en_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic                wake_o,
  output logic                bkp_clr_o
);

  logic [NUM_PINS-1:0] sticky_q;
  logic [NUM_PINS-1:0] sticky_d;

  // a coincident event wins over the read
  assign sticky_d = (sticky_q & ~{NUM_PINS{rd_i}}) | evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= sticky_d;
  end

  assign status_o  = sticky_q;
  assign wake_o    = |evt_i;
  assign bkp_clr_o = clr_en_i & (|evt_i);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    assert_status_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> sticky_q[i]);
    assert_status_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !evt_i[i]) |=> !sticky_q[i]);
  end

  assert_clr_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkp_clr_o |=> !bkp_clr_o);

endmodule

// File: rtl/lp_wake_debouncer.sv
module lp_wake_debouncer #(
  parameter int unsigned NUM_PINS = 2,
  parameter int unsigned PERIOD_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] pin_en_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                clr_en_i,
  input  logic                status_rd_i,
  output logic                wake_o,
  output logic [NUM_PINS-1:0] status_o,
  output logic                bkp_clr_o
);

  logic [NUM_PINS-1:0] pin_s;
  logic [NUM_PINS-1:0] active;
  logic [NUM_PINS-1:0] evt;

  lpdb_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  assign active = ~(pin_s ^ pol_i);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ch
    lpdb_channel #(.PERIOD_W(PERIOD_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .active_i (active[i]),
      .enable_i (pin_en_i[i]),
      .period_i (period_i),
      .evt_o    (evt[i])
    );
  end

  lpdb_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .rd_i      (status_rd_i),
    .clr_en_i  (clr_en_i),
    .status_o  (status_o),
    .wake_o    (wake_o),
    .bkp_clr_o (bkp_clr_o)
  );

  assert_clr_needs_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkp_clr_o |-> (wake_o && clr_en_i));

  assert_wake_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ($past(pin_en_i) != '0));

endmodule

// File: tb/lp_wake_debouncer_test.sv
module lp_wake_debouncer_test;

  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] pin_i = 2'b00;
  logic [1:0] pol_i = 2'b11;
  logic [1:0] pin_en_i = 2'b00;
  logic [2:0] period_i = 3'd0;
  logic       clr_en_i = 1'b0;
  logic       status_rd_i = 1'b0;
  logic       wake_o;
  logic [1:0] status_o;
  logic       bkp_clr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lp_wake_debouncer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .pin_i(pin_i),
    .pol_i(pol_i), .pin_en_i(pin_en_i), .period_i(period_i),
    .clr_en_i(clr_en_i), .status_rd_i(status_rd_i),
    .wake_o(wake_o), .status_o(status_o), .bkp_clr_o(bkp_clr_o)
  );

  // [15:13] period, [12] en, [11] pol, [10] clr_en, [9] pin, [8:5] ticks, [4:1] expected firing tick (0 = none)
  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{
    {3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 4'd2, 1'b0},
    {3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 4'd9, 4'd8, 1'b0},
    {3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6, 4'd5, 1'b0},
    {3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3, 4'd0, 1'b0},
    {3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd9, 4'd0, 1'b0},
    {3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5, 4'd0, 1'b0},
    {3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 4'd6, 4'd6, 1'b0},
    {3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8, 4'd7, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_pin(input int p, input bit act);
    pin_i[p] = act ? pol_i[p] : ~pol_i[p];
  endtask

  task automatic read_status();
    @(negedge clk_i) status_rd_i = 1'b1;
    @(negedge clk_i) status_rd_i = 1'b0;
  endtask

  // applies n ticks; reports the first tick index that gave a wake pulse
  task automatic apply_ticks(input int n, output int first, output int fires, output bit clr_seen);
    first = 0; fires = 0; clr_seen = 1'b0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk_i) tick_i = 1'b1;
      @(negedge clk_i) tick_i = 1'b0;
      if (wake_o) begin
        fires++;
        if (first == 0) first = k;
      end
      if (bkp_clr_o) clr_seen = 1'b1;
      @(negedge clk_i);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int first, fires;
    bit clr_seen;
    logic [1:0] got;

    // R10 reset state
    repeat (3) @(negedge clk_i);
    check(wake_o == 1'b0 && bkp_clr_o == 1'b0, "R10 reset wake/clr", int'({wake_o, bkp_clr_o}), 0);
    check(status_o == 2'b00, "R10 reset status", int'(status_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // table walk: R1 R2 R3 R4 R5 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      int p;
      logic [15:0] e;
      e = VEC[v];
      p = int'(e[9]);
      period_i = e[15:13];
      clr_en_i = e[10];
      pol_i = 2'b11;
      pol_i[p] = e[11];
      pin_en_i = 2'b00;
      pin_en_i[p] = e[12];
      pin_i = 2'b00;
      set_pin(p, 1'b0);
      read_status();
      repeat (3) @(negedge clk_i);
      set_pin(p, 1'b1);
      repeat (3) @(negedge clk_i);
      apply_ticks(int'(e[8:5]), first, fires, clr_seen);
      check(first == int'(e[4:1]), "R1/R2/R8 firing tick", first, int'(e[4:1]));
      check(fires == ((e[4:1] != 0) ? 1 : 0), "R3/R7 wake pulse count", fires, (e[4:1] != 0) ? 1 : 0);
      check(clr_seen == (e[10] && e[4:1] != 0), "R5 backup clear", int'(clr_seen), int'(e[10] && e[4:1] != 0));
      check(status_o == ((e[4:1] != 0) ? (2'b01 << p) : 2'b00), "R4 status set",
            int'(status_o), int'((e[4:1] != 0) ? (2'b01 << p) : 2'b00));
      set_pin(p, 1'b0);
      read_status();
      check(status_o == 2'b00, "R4 status cleared by read", int'(status_o), 0);
    end

    // R6: counter restarts after glitch
    period_i = 3'd3; pol_i = 2'b11; pin_en_i = 2'b01; clr_en_i = 1'b0; pin_i = 2'b00;
    repeat (3) @(negedge clk_i);
    set_pin(0, 1'b1); repeat (3) @(negedge clk_i);
    apply_ticks(3, first, fires, clr_seen);
    set_pin(0, 1'b0); repeat (3) @(negedge clk_i);
    set_pin(0, 1'b1); repeat (3) @(negedge clk_i);
    apply_ticks(3, first, fires, clr_seen);
    check(fires == 0, "R6 no event after restart", fires, 0);
    apply_ticks(1, first, fires, clr_seen);
    check(fires == 1, "R6 event on fourth tick after restart", fires, 1);

    // R7: held active gives no second event, release re-arms
    apply_ticks(5, first, fires, clr_seen);
    check(fires == 0, "R7 no repeat while held", fires, 0);
    set_pin(0, 1'b0); repeat (3) @(negedge clk_i);
    set_pin(0, 1'b1); repeat (3) @(negedge clk_i);
    apply_ticks(4, first, fires, clr_seen);
    check(first == 4, "R7 re-armed after release", first, 4);
    set_pin(0, 1'b0);
    read_status();

    // R4: read coincident with status set keeps the bit
    set_pin(0, 1'b1); repeat (3) @(negedge clk_i);
    apply_ticks(3, first, fires, clr_seen);
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) begin tick_i = 1'b0; status_rd_i = 1'b1; end
    check(wake_o == 1'b1, "R4 wake before coincident read", int'(wake_o), 1);
    @(negedge clk_i) status_rd_i = 1'b0;
    check(status_o[0] == 1'b1, "R4 set wins over read", int'(status_o[0]), 1);
    read_status();
    check(status_o == 2'b00, "R4 cleared by later read", int'(status_o), 0);
    set_pin(0, 1'b0);

    // R3: both pins at once, single pulse, both status bits
    period_i = 3'd1; pin_en_i = 2'b11; pol_i = 2'b10; clr_en_i = 1'b1;
    set_pin(0, 1'b0); set_pin(1, 1'b0);
    repeat (3) @(negedge clk_i);
    set_pin(0, 1'b1); set_pin(1, 1'b1);
    repeat (3) @(negedge clk_i);
    apply_ticks(2, first, fires, clr_seen);
    check(fires == 1 && first == 2, "R3 merged wake pulse", fires, 1);
    check(status_o == 2'b11, "R4 both status bits", int'(status_o), 3);
    check(clr_seen == 1'b1, "R5 clear on dual event", int'(clr_seen), 1);
    set_pin(0, 1'b0); set_pin(1, 1'b0);
    read_status();

    // R9: ticks on the first two edges after a pin change are not counted
    pin_en_i = 2'b01; pol_i = 2'b11; pin_i = 2'b00; clr_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    pin_i[0] = 1'b1; tick_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      got = {got[0], wake_o};
      if (k == 2) check(wake_o == 1'b0, "R9 no event by third edge", int'(wake_o), 0);
    end
    tick_i = 1'b0;
    check(got[0] == 1'b1, "R9 event on fourth edge", int'(got[0]), 1);
    pin_i = 2'b00;
    read_status();

    // R1: idle cycles without tick do not count
    pin_en_i = 2'b01; period_i = 3'd2;
    set_pin(0, 1'b1);
    repeat (20) @(negedge clk_i);
    check(wake_o == 1'b0 && status_o == 2'b00, "R1 no count without tick", int'(status_o), 0);
    set_pin(0, 1'b0);

    done = 1'b1;
    finish_run();
  end

endmodule